// File: doc/BRIEF.md
# Shadowed-Period Up-Counting Timer

This block is a 16-bit up-counting timer with a small word-addressed register file. A prescaler counts input clocks. Each time it reaches its terminal value it sends a tick to the main counter. The counter climbs until it reaches the active period value, then returns to zero. That return, a software trigger or a trigger from a neighbouring slave controller can raise an update event. The update event sets a status flag and loads the buffered period and prescaler values into the counter logic.

Software programs the control word, the period and the prescaler over a simple write/read bus. The control word selects the following options:
- period writes go to a preload copy instead of taking effect at once;
- the timer halts itself at its next update event;
- only a true counter wrap may produce updates;
- updates are inhibited altogether.

A debug pause input freezes the count. A separate sampling strobe output pulses at a rate chosen by a 2-bit field.

Top module: `tmr_core`

## Requirements
- R1: After reset every register (control 0x00, interrupt enable 0x0C, flags 0x10, event 0x14, count 0x24, prescaler 0x28, period 0x2C) reads zero and `irq` is low.
- R2: With the run bit (control bit 0) set, the count rises by one per prescaler tick and returns to zero on the tick after it reaches the active period. That wrap raises `update_evt` during the terminal cycle and sets flag bit 0 on the following edge. Writing 0 to flag bit 0 clears it and writing 1 leaves it. `irq` equals flag bit 0 AND enable bit 0.
- R3: With the shadow bit (control bit 4) set, a period write changes only the readable preload value, and the active period takes it at the next update event. With bit 4 clear, a period write is active on the next edge.
- R4: With the single-shot bit (control bit 1) set, an update event clears the run bit, and the count then holds.
- R5: With the source bit (control bit 2) clear, a software trigger or a high `slave_trig` raises an update event. With it set, only a counter wrap does.
- R6: With the inhibit bit (control bit 3) set, the counter still wraps, but no update event occurs, the flag is not set and no preload is transferred.
- R7: Writing 1 to event bit 0 returns the count and the prescaler to zero. The event register reads zero.
- R8: The prescaler divides ticks by its value plus one, and a new value takes effect at the next update event.
- R9: While `debug_pause` is high, the count and the prescaler hold.
- R10: Control bits 6:5 set the `sample_strobe` rate. 00 pulses every cycle, 01 every 2nd cycle, 10 every 4th cycle and 11 every cycle.
- R11: Control bits 15:7 read zero whatever was written.
- R12: Writing the count register loads that value into the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| debug_pause | input | 1 | Freezes counter and prescaler |
| slave_trig | input | 1 | Update request from a slave controller |
| irq | output | 1 | Flag bit 0 gated by enable bit 0 |
| update_evt | output | 1 | Update event of the current cycle |
| sample_strobe | output | 1 | Divided sampling strobe |

## Verification
A register write is applied on the edge that ends its bus cycle, so its value can be read at the falling edge after that edge. Once the run bit has been written, the count advances on every later edge at prescaler zero. `update_evt` is combinational and is high in the same cycle that the count equals the period. The flag, the run-bit clear and the preload transfers all appear one edge after that cycle. The bench drives inputs at falling edges and waits a fraction of a nanosecond before queuing each expected value. The monitor compares each queued value before the next input change, so every comparison lands in the cycle computed above.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam logic [7:0] OFS_CTRL = 8'h00;
    localparam logic [7:0] OFS_IEN  = 8'h0C;
    localparam logic [7:0] OFS_FLAG = 8'h10;
    localparam logic [7:0] OFS_EVG  = 8'h14;
    localparam logic [7:0] OFS_CNT  = 8'h24;
    localparam logic [7:0] OFS_PSC  = 8'h28;
    localparam logic [7:0] OFS_PER  = 8'h2C;

    localparam int CTRL_W    = 7;
    localparam int B_RUN     = 0;
    localparam int B_ONESHOT = 1;
    localparam int B_OVFONLY = 2;
    localparam int B_INHIBIT = 3;
    localparam int B_SHADOW  = 4;
    localparam int B_DIV_LO  = 5;

    typedef enum logic [1:0] {
        DIV_BY1  = 2'b00,
        DIV_BY2  = 2'b01,
        DIV_BY4  = 2'b10,
        DIV_RSVD = 2'b11
    } sdiv_e;
endpackage

// File: rtl/tmr_strobe.sv
module tmr_strobe import tmr_pkg::*; #(
    parameter int PW = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] div_sel,
    output logic       strobe
);
    typedef struct packed {
        logic [PW-1:0] phase;
    } st_t;

    st_t s_q, s_d;
    logic [PW-1:0] mask;

    always_comb begin
        s_d       = s_q;
        s_d.phase = s_q.phase + 1'b1;
        case (sdiv_e'(div_sel))
            DIV_BY2: mask = PW'(1);
            DIV_BY4: mask = PW'(3);
            default: mask = '0;
        endcase
        strobe = ((s_q.phase & mask) == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R10: at divide-by-2 a strobe is never followed by another one
    assert_div2_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (div_sel == 2'b01 && strobe) |=> (div_sel != 2'b01 || !strobe));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          pause,
    input  logic [DW-1:0] period_act,
    input  logic [DW-1:0] psc_act,
    input  logic          cnt_wr,
    input  logic [DW-1:0] wdata,
    input  logic          sw_evt,
    input  logic          slave_trig,
    input  logic          ovf_only,
    input  logic          upd_inhibit,
    output logic [DW-1:0] cnt_val,
    output logic          upd
);
    typedef struct packed {
        logic [DW-1:0] cnt;
        logic [DW-1:0] psc_cnt;
    } st_t;

    st_t  s_q, s_d;
    logic active, term, tick, wrap;

    always_comb begin
        s_d    = s_q;
        active = run && !pause;
        term   = (s_q.psc_cnt == psc_act);
        tick   = active && term;
        wrap   = tick && (s_q.cnt >= period_act);
        if (active) begin
            s_d.psc_cnt = term ? '0 : s_q.psc_cnt + 1'b1;
        end
        if (tick) begin
            s_d.cnt = wrap ? '0 : s_q.cnt + 1'b1;
        end
        if (sw_evt) begin
            s_d.cnt     = '0;
            s_d.psc_cnt = '0;
        end
        if (cnt_wr) begin
            s_d.cnt = wdata;
        end
        upd = !upd_inhibit && (wrap || (!ovf_only && (sw_evt || slave_trig)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt_val = s_q.cnt;

    assert_pause_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pause && !cnt_wr && !sw_evt) |=> $stable(s_q.cnt));

    assert_wrap_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !cnt_wr && !sw_evt) |=> (s_q.cnt == '0));

    assert_swevt_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_evt && !cnt_wr) |=> (s_q.cnt == '0 && s_q.psc_cnt == '0));

    assert_ovf_only_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && ovf_only) |-> wrap);
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs import tmr_pkg::*; #(
    parameter int DW = 16,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          upd,
    input  logic [DW-1:0] cnt_val,
    output logic          run,
    output logic          single_shot,
    output logic          ovf_only,
    output logic          upd_inhibit,
    output logic          shadow_en,
    output logic [1:0]    sample_div,
    output logic [DW-1:0] period_act,
    output logic [DW-1:0] psc_act,
    output logic          cnt_wr,
    output logic          sw_evt,
    output logic          irq
);
    localparam int CW = CTRL_W;

    typedef struct packed {
        logic [CW-1:0] ctrl;
        logic          irq_en;
        logic          flag;
        logic [DW-1:0] psc_pre;
        logic [DW-1:0] psc_act;
        logic [DW-1:0] per_pre;
        logic [DW-1:0] per_act;
    } regs_t;

    regs_t r_q, r_d;
    logic  wr, hit_ctrl, hit_ien, hit_flag, hit_evg, hit_cnt, hit_psc, hit_per;

    always_comb begin
        wr       = bus_sel && bus_wr;
        hit_ctrl = wr && (bus_addr == AW'(OFS_CTRL));
        hit_ien  = wr && (bus_addr == AW'(OFS_IEN));
        hit_flag = wr && (bus_addr == AW'(OFS_FLAG));
        hit_evg  = wr && (bus_addr == AW'(OFS_EVG));
        hit_cnt  = wr && (bus_addr == AW'(OFS_CNT));
        hit_psc  = wr && (bus_addr == AW'(OFS_PSC));
        hit_per  = wr && (bus_addr == AW'(OFS_PER));
    end

    always_comb begin
        r_d = r_q;
        // update transfers first, so a bus write in the same cycle wins
        if (upd) begin
            r_d.per_act = r_q.per_pre;
            r_d.psc_act = r_q.psc_pre;
            if (r_q.ctrl[B_ONESHOT]) r_d.ctrl[B_RUN] = 1'b0;
        end
        if (hit_ctrl) r_d.ctrl   = bus_wdata[CW-1:0];
        if (hit_ien)  r_d.irq_en = bus_wdata[0];
        if (hit_flag && !bus_wdata[0]) r_d.flag = 1'b0;
        if (hit_psc)  r_d.psc_pre = bus_wdata;
        if (hit_per) begin
            r_d.per_pre = bus_wdata;
            if (!r_q.ctrl[B_SHADOW]) r_d.per_act = bus_wdata;
        end
        // a new event outranks a clearing write
        if (upd) r_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            AW'(OFS_CTRL): bus_rdata = {{(DW-CW){1'b0}}, r_q.ctrl};
            AW'(OFS_IEN):  bus_rdata = {{(DW-1){1'b0}}, r_q.irq_en};
            AW'(OFS_FLAG): bus_rdata = {{(DW-1){1'b0}}, r_q.flag};
            AW'(OFS_CNT):  bus_rdata = cnt_val;
            AW'(OFS_PSC):  bus_rdata = r_q.psc_pre;
            AW'(OFS_PER):  bus_rdata = r_q.per_pre;
            default:       bus_rdata = '0;
        endcase
    end

    assign run         = r_q.ctrl[B_RUN];
    assign single_shot = r_q.ctrl[B_ONESHOT];
    assign ovf_only    = r_q.ctrl[B_OVFONLY];
    assign upd_inhibit = r_q.ctrl[B_INHIBIT];
    assign shadow_en   = r_q.ctrl[B_SHADOW];
    assign sample_div  = r_q.ctrl[B_DIV_LO +: 2];
    assign period_act  = r_q.per_act;
    assign psc_act     = r_q.psc_act;
    assign cnt_wr      = hit_cnt;
    assign sw_evt      = hit_evg && bus_wdata[0];
    assign irq         = r_q.flag && r_q.irq_en;

    assert_oneshot_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && single_shot && !hit_ctrl) |=> !run);

    assert_flag_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> r_q.flag);

    assert_inhibit_noflag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_inhibit && !r_q.flag) |=> !r_q.flag);

    assert_shadow_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (shadow_en && !upd) |=> $stable(r_q.per_act));
endmodule

// File: rtl/tmr_core.sv
module tmr_core import tmr_pkg::*; #(
    parameter int DW = 16,
    parameter int AW = 8,
    parameter int PW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          debug_pause,
    input  logic          slave_trig,
    output logic          irq,
    output logic          update_evt,
    output logic          sample_strobe
);
    logic          run, single_shot, ovf_only, upd_inhibit, shadow_en;
    logic [1:0]    sample_div;
    logic [DW-1:0] period_act, psc_act, cnt_val;
    logic          cnt_wr, sw_evt, upd;

    tmr_regs #(.DW(DW), .AW(AW)) i_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .upd(upd), .cnt_val(cnt_val),
        .run(run), .single_shot(single_shot), .ovf_only(ovf_only),
        .upd_inhibit(upd_inhibit), .shadow_en(shadow_en),
        .sample_div(sample_div), .period_act(period_act), .psc_act(psc_act),
        .cnt_wr(cnt_wr), .sw_evt(sw_evt), .irq(irq)
    );

    tmr_counter #(.DW(DW)) i_counter (
        .clk(clk), .rst_n(rst_n),
        .run(run), .pause(debug_pause),
        .period_act(period_act), .psc_act(psc_act),
        .cnt_wr(cnt_wr), .wdata(bus_wdata), .sw_evt(sw_evt),
        .slave_trig(slave_trig), .ovf_only(ovf_only), .upd_inhibit(upd_inhibit),
        .cnt_val(cnt_val), .upd(upd)
    );

    tmr_strobe #(.PW(PW)) i_strobe (
        .clk(clk), .rst_n(rst_n),
        .div_sel(sample_div), .strobe(sample_strobe)
    );

    assign update_evt = upd;
endmodule

// File: tb/test_tmr_core.sv
`timescale 1ns/100ps
module test_tmr_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        debug_pause = 1'b0, slave_trig = 1'b0;
    logic        irq, update_evt, sample_strobe;

    localparam logic [7:0] A_CTRL = 8'h00, A_IEN = 8'h0C, A_FLAG = 8'h10,
                           A_EVG = 8'h14, A_CNT = 8'h24, A_PSC = 8'h28, A_PER = 8'h2C;
    localparam int K_RD = 0, K_IRQ = 1, K_UPD = 2, K_VAL = 3;

    typedef struct {
        int          kind;
        logic [15:0] exp;
        logic [15:0] val;
        string       tag;
    } item_t;

    item_t q[$];
    event  push_ev;
    int    n_checks = 0, n_fail = 0;
    bit    done = 1'b0;

    tmr_core i_tmr_core (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .debug_pause(debug_pause), .slave_trig(slave_trig),
        .irq(irq), .update_evt(update_evt), .sample_strobe(sample_strobe)
    );

    always #5 clk = ~clk;

    // monitor: drains expected items and compares with the live outputs
    initial begin
        forever begin
            @(push_ev);
            while (q.size() > 0) begin
                item_t it;
                logic [15:0] act;
                it = q.pop_front();
                case (it.kind)
                    K_RD:    act = bus_rdata;
                    K_IRQ:   act = {15'h0, irq};
                    K_UPD:   act = {15'h0, update_evt};
                    default: act = it.val;
                endcase
                n_checks++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic push(input int kind, input logic [15:0] exp, input logic [15:0] val, input string tag);
        item_t it;
        #0.2;
        it.kind = kind; it.exp = exp; it.val = val; it.tag = tag;
        q.push_back(it);
        -> push_ev;
        #0.2;
    endtask

    task automatic chk(input logic [7:0] a, input logic [15:0] exp, input string tag);
        bus_addr = a;
        push(K_RD, exp, 16'h0, tag);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        debug_pause = 1'b0; slave_trig = 1'b0;
        step(2);
        rst_n = 1'b1;
        step(1);
    endtask

    task automatic strobe_count(input int n, input logic [15:0] exp, input string tag);
        int c = 0;
        for (int i = 0; i < n; i++) begin
            #0.2;
            c += int'(sample_strobe);
            step(1);
        end
        push(K_VAL, exp, 16'(c), tag);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1 reset values
        chk(A_CTRL, 16'h0, "R1 ctrl");
        chk(A_IEN,  16'h0, "R1 ien");
        chk(A_FLAG, 16'h0, "R1 flag");
        chk(A_EVG,  16'h0, "R1 evg");
        chk(A_CNT,  16'h0, "R1 cnt");
        chk(A_PSC,  16'h0, "R1 psc");
        chk(A_PER,  16'h0, "R1 per");
        push(K_IRQ, 16'h0, 16'h0, "R1 irq");

        // R11 reserved control bits
        wr(A_CTRL, 16'hFFFF);
        chk(A_CTRL, 16'h007F, "R11 reserved");
        do_reset();

        // R12 count load, held while stopped
        wr(A_CNT, 16'h1234);
        chk(A_CNT, 16'h1234, "R12 load");
        step(2);
        chk(A_CNT, 16'h1234, "R12 hold");

        // R2 count, wrap, flag, irq
        do_reset();
        wr(A_PER, 16'd3);
        wr(A_CTRL, 16'h0001);
        chk(A_CNT, 16'd0, "R2 start");
        for (int k = 1; k <= 3; k++) begin
            step(1);
            chk(A_CNT, 16'(k), "R2 count");
        end
        push(K_UPD, 16'h1, 16'h0, "R2 upd at terminal");
        step(1);
        chk(A_CNT, 16'd0, "R2 wrap");
        chk(A_FLAG, 16'h1, "R2 flag set");
        push(K_IRQ, 16'h0, 16'h0, "R2 irq masked");
        wr(A_IEN, 16'h1);
        push(K_IRQ, 16'h1, 16'h0, "R2 irq enabled");
        wr(A_CTRL, 16'h0000);
        wr(A_FLAG, 16'h1);
        chk(A_FLAG, 16'h1, "R2 write one keeps");
        wr(A_FLAG, 16'h0);
        chk(A_FLAG, 16'h0, "R2 flag clear");
        push(K_IRQ, 16'h0, 16'h0, "R2 irq clear");

        // R3 shadowed period
        do_reset();
        wr(A_PER, 16'd3);
        wr(A_CTRL, 16'h0011);
        wr(A_PER, 16'd1);
        chk(A_CNT, 16'd1, "R3 shadow seq");
        begin
            logic [15:0] s3 [5] = '{16'd2, 16'd3, 16'd0, 16'd1, 16'd0};
            for (int i = 0; i < 5; i++) begin
                step(1);
                chk(A_CNT, s3[i], "R3 shadow seq");
            end
        end
        chk(A_PER, 16'd1, "R3 preload read");
        // R3 immediate period
        do_reset();
        wr(A_PER, 16'd5);
        wr(A_CTRL, 16'h0001);
        wr(A_PER, 16'd2);
        step(1);
        chk(A_CNT, 16'd2, "R3 immediate");
        step(1);
        chk(A_CNT, 16'd0, "R3 immediate wrap");

        // R4 single shot
        do_reset();
        wr(A_PER, 16'd2);
        wr(A_CTRL, 16'h0003);
        step(3);
        chk(A_CNT, 16'd0, "R4 wrapped");
        chk(A_CTRL, 16'h0002, "R4 run cleared");
        step(2);
        chk(A_CNT, 16'd0, "R4 holds");

        // R7 software event, R5 source clear
        do_reset();
        wr(A_PER, 16'd9);
        wr(A_CTRL, 16'h0001);
        step(3);
        chk(A_CNT, 16'd3, "R7 before");
        wr(A_EVG, 16'h1);
        chk(A_CNT, 16'd0, "R7 reinit");
        chk(A_FLAG, 16'h1, "R5 sw event updates");
        chk(A_EVG, 16'h0, "R7 reads zero");
        step(1);
        chk(A_CNT, 16'd1, "R7 resumes");

        // R5 overflow-only source
        do_reset();
        wr(A_PER, 16'd9);
        wr(A_CTRL, 16'h0005);
        step(2);
        wr(A_EVG, 16'h1);
        chk(A_CNT, 16'd0, "R7 reinit ovf-only");
        chk(A_FLAG, 16'h0, "R5 sw ignored");
        slave_trig = 1'b1;
        push(K_UPD, 16'h0, 16'h0, "R5 slave ignored");
        wr(A_CTRL, 16'h0001);
        push(K_UPD, 16'h1, 16'h0, "R5 slave accepted");
        step(1);
        slave_trig = 1'b0;
        chk(A_FLAG, 16'h1, "R5 slave flag");

        // R6 inhibit
        do_reset();
        wr(A_PER, 16'd2);
        wr(A_CTRL, 16'h0019);
        wr(A_PER, 16'd7);
        chk(A_CNT, 16'd1, "R6 seq");
        step(1);
        chk(A_CNT, 16'd2, "R6 seq");
        push(K_UPD, 16'h0, 16'h0, "R6 no upd");
        begin
            logic [15:0] s6 [4] = '{16'd0, 16'd1, 16'd2, 16'd0};
            for (int i = 0; i < 4; i++) begin
                step(1);
                chk(A_CNT, s6[i], "R6 seq no transfer");
            end
        end
        chk(A_FLAG, 16'h0, "R6 no flag");

        // R8 prescaler latched at update
        do_reset();
        wr(A_PER, 16'd5);
        wr(A_PSC, 16'd1);
        wr(A_CTRL, 16'h0001);
        begin
            logic [15:0] s8 [10] = '{16'd1, 16'd2, 16'd3, 16'd4, 16'd5,
                                     16'd0, 16'd0, 16'd1, 16'd1, 16'd2};
            for (int i = 0; i < 10; i++) begin
                step(1);
                chk(A_CNT, s8[i], "R8 prescale");
            end
        end
        chk(A_PSC, 16'd1, "R8 read");

        // R9 debug pause
        do_reset();
        wr(A_PER, 16'd9);
        wr(A_CTRL, 16'h0001);
        step(1);
        chk(A_CNT, 16'd1, "R9 before");
        debug_pause = 1'b1;
        step(1);
        chk(A_CNT, 16'd1, "R9 held");
        step(1);
        chk(A_CNT, 16'd1, "R9 held");
        debug_pause = 1'b0;
        step(1);
        chk(A_CNT, 16'd2, "R9 resumes");

        // R10 sampling strobe
        do_reset();
        strobe_count(8, 16'd8, "R10 div1");
        wr(A_CTRL, 16'h0020);
        strobe_count(8, 16'd4, "R10 div2");
        wr(A_CTRL, 16'h0040);
        strobe_count(8, 16'd2, "R10 div4");
        wr(A_CTRL, 16'h0060);
        strobe_count(8, 16'd8, "R10 reserved");

        step(2);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule